// File: doc/BRIEF.md
# Time-shared second-order recursive filter

This block is a second-order recursive (IIR) filter. Its four additions and four constant multiplications do not each get their own hardware. They share one adder, which has one register stage, and one multiplier, which has two register stages. A free-running two-bit slot counter assigns each shared unit a different operation in each of four slots. One filter iteration therefore takes four clock cycles, and the block consumes one sample and emits one sample per iteration.

The internal state is a recurrence `w(n) = x(n) + A·w(n-1) + C·w(n-2)`. The output is `y(n) = w(n-1) + B·w(n-2) + D·w(n-3)`. The delay from each operation's result to each of its consumers is worked out in cycles. Each unit's result then runs down a short register chain, and every operand multiplexer picks the tap whose age matches that distance. The four coefficients are elaboration-time parameters.

The producer watches `in_ready`, which is high for one cycle per iteration, and presents a sample on `in_valid`/`in_data` in that cycle. A sample is emitted with `out_valid` and held on `y_out` until the next one.

Top module: `biq_folded`

## Requirements
- R1: While `rst` is high, `out_valid`, `y_out` and `in_ready` are all 0. The slot counter and all history registers clear, so the first cycle after `rst` falls is slot 0.
- R2: Counting cycles from the first cycle after reset as cycle 0, `in_ready` is high exactly in cycles where cycle mod 4 = 2. `out_valid` is high exactly in cycles where cycle mod 4 = 3, which is always the cycle right after `in_ready`.
- R3: A sample is taken only from a cycle where `in_ready` is high. If `in_valid` is low in that cycle, the iteration uses the value 0. An `in_valid` or `in_data` value outside that cycle has no effect on any later `y_out`.
- R4: Let x(k) be the value taken in iteration k, with w(j) = 0 for j < 0. Then w(k) = x(k) + A·w(k-1) + C·w(k-2), and the strobe of iteration l carries y(l) = w(l-1) + B·w(l-2) + D·w(l-3).
- R5: A sample taken at the `in_ready` of iteration k first shows on `y_out` at the `out_valid` of iteration k+1, five cycles later. An isolated impulse of height h after a zero history therefore gives 0 at the strobe of iteration k and h at the strobe of iteration k+1.
- R6: Samples and coefficients are W-bit two's complement, and coefficients carry F fractional bits. Each product is the full product arithmetically shifted right by F (rounding toward minus infinity) and cut to W bits. Each sum wraps modulo 2^W.
- R7: Between strobes, `y_out` holds the value of the most recent strobe, or 0 if there has been none since reset.
- R8: A reset in the middle of operation discards all history, and the filter afterwards behaves exactly as it does from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present on `in_data` (only looked at while `in_ready` is high) |
| in_data | input | W | Signed input sample |
| in_ready | output | 1 | Sample window: high one cycle per four-cycle iteration |
| out_valid | output | 1 | One-cycle strobe marking a new output sample |
| y_out | output | W | Signed output sample, held between strobes |

## Verification
The assertions take for granted a synchronous `rst` that lasts at least one rising edge. They place no limit on when `in_valid` or `in_data` may toggle, because the block itself must ignore values outside the window. The stimulus changes the inputs only on falling edges. It includes windows with no sample, stray strobes and saturating data outside the window, full-range random samples that force wrap-around, and a reset in the middle of a run. A behavioural reference built on integer arithmetic checks the window and strobe pattern and the held output on every cycle.

// File: rtl/biq_pkg.sv
`timescale 1ns/1ps
package biq_pkg;
  // iteration length and unit pipeline depths (the datapath is built around these)
  localparam int FOLD    = 4;
  localparam int SLOT_W  = $clog2(FOLD);
  localparam int ADD_LAT = 1;
  localparam int MUL_LAT = 2;

  typedef logic [SLOT_W-1:0] slot_t;

  // slot each operation occupies on its shared unit
  localparam int ORD_ADD4 = 0;  // output partial sum  B*w + D*w
  localparam int ORD_ADD2 = 1;  // output              w + partial
  localparam int ORD_ADD3 = 2;  // feedback partial    A*w + C*w
  localparam int ORD_ADD1 = 3;  // state               x + feedback
  localparam int ORD_MUL5 = 0;  // A * w(n-1)
  localparam int ORD_MUL8 = 1;  // D * w(n-2), summed one iteration later
  localparam int ORD_MUL6 = 2;  // B * w(n-1), summed one iteration later
  localparam int ORD_MUL7 = 3;  // C * w(n-1), summed one iteration later

  // cycles a result must wait after leaving its unit before the consumer reads it
  function automatic int hold_cycles(int iters, int src_ord, int dst_ord, int src_lat);
    return FOLD * iters + dst_ord - src_ord - src_lat;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/biq_slot_ctr.sv
`timescale 1ns/1ps
module biq_slot_ctr
  import biq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_t slot
);
  localparam slot_t LAST = slot_t'(FOLD - 1);

  always_ff @(posedge clk) begin
    if (rst)               slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end
endmodule

// File: rtl/biq_tapline.sv
`timescale 1ns/1ps
module biq_tapline #(
  parameter int W     = 16,
  parameter int DEPTH = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [W-1:0]           d,
  output logic [DEPTH:0][W-1:0]  taps
);
  logic [W-1:0] stg [DEPTH];
  logic         seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
      seen <= 1'b0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
      seen <= 1'b1;
    end
  end

  always_comb begin
    taps[0] = d;
    for (int k = 1; k <= DEPTH; k++) taps[k] = stg[k-1];
  end

  // the oldest tap is the next-oldest one cycle later
  AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    seen |-> taps[DEPTH] == $past(taps[DEPTH-1])); // R4
endmodule

// File: rtl/biq_pipe_mul.sv
`timescale 1ns/1ps
module biq_pipe_mul #(
  parameter int W = 16,
  parameter int F = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] q
);
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] scale_prod(logic signed [PW-1:0] p);
    logic signed [PW-1:0] s;
    s = p >>> F;
    return s[W-1:0];
  endfunction

  logic signed [PW-1:0] prod_c, prod_r;
  logic [1:0]           warm;

  assign prod_c = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_r <= '0;
      q      <= '0;
      warm   <= '0;
    end else begin
      prod_r <= prod_c;
      q      <= scale_prod(prod_r);
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  // result appears exactly two edges after its operands
  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> q == scale_prod($past(prod_c, 2))); // R6
endmodule

// File: rtl/biq_pipe_add.sv
`timescale 1ns/1ps
module biq_pipe_add #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] add_wrap(logic [W-1:0] x, logic [W-1:0] y);
    return x + y;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= add_wrap(a, b);
  end
endmodule

// File: rtl/biq_folded.sv
`timescale 1ns/1ps
module biq_folded
  import biq_pkg::*;
#(
  parameter int W      = 16,
  parameter int F      = 14,
  parameter int COEF_A = 8192,
  parameter int COEF_B = 12288,
  parameter int COEF_C = -4096,
  parameter int COEF_D = -6144
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] y_out
);
  localparam logic [W-1:0] K_A = W'(COEF_A);
  localparam logic [W-1:0] K_B = W'(COEF_B);
  localparam logic [W-1:0] K_C = W'(COEF_C);
  localparam logic [W-1:0] K_D = W'(COEF_D);

  // tap ages per edge (iterations of delay, source slot, sink slot, source latency)
  localparam int H_1_2 = hold_cycles(1, ORD_ADD1, ORD_ADD2, ADD_LAT);
  localparam int H_1_5 = hold_cycles(1, ORD_ADD1, ORD_MUL5, ADD_LAT);
  localparam int H_1_6 = hold_cycles(1, ORD_ADD1, ORD_MUL6, ADD_LAT);
  localparam int H_1_7 = hold_cycles(1, ORD_ADD1, ORD_MUL7, ADD_LAT);
  localparam int H_1_8 = hold_cycles(2, ORD_ADD1, ORD_MUL8, ADD_LAT);
  localparam int H_3_1 = hold_cycles(0, ORD_ADD3, ORD_ADD1, ADD_LAT);
  localparam int H_4_2 = hold_cycles(0, ORD_ADD4, ORD_ADD2, ADD_LAT);
  localparam int H_5_3 = hold_cycles(0, ORD_MUL5, ORD_ADD3, MUL_LAT);
  localparam int H_6_4 = hold_cycles(1, ORD_MUL6, ORD_ADD4, MUL_LAT);
  localparam int H_7_3 = hold_cycles(1, ORD_MUL7, ORD_ADD3, MUL_LAT);
  localparam int H_8_4 = hold_cycles(1, ORD_MUL8, ORD_ADD4, MUL_LAT);

  localparam int ADD_DEPTH = max2(max2(max2(H_1_2, H_1_5), max2(H_1_6, H_1_7)),
                                  max2(max2(H_1_8, H_3_1), H_4_2));
  localparam int MUL_DEPTH = max2(max2(H_5_3, H_6_4), max2(H_7_3, H_8_4));

  // x is loaded in the slot before the state adder, y captured once the output sum is out
  localparam slot_t LOAD_SLOT = slot_t'(ORD_ADD1 - 1);
  localparam slot_t CAP_SLOT  = slot_t'(ORD_ADD2 + ADD_LAT);

  slot_t                          slot;
  logic [W-1:0]                   x_hold;
  logic [W-1:0]                   add_a, add_b, mul_a, mul_k;
  logic [W-1:0]                   add_q, mul_q;
  logic [ADD_DEPTH:0][W-1:0]      add_taps;
  logic [MUL_DEPTH:0][W-1:0]      mul_taps;
  logic [W-1:0]                   y_q;

  biq_slot_ctr u_slot (.clk(clk), .rst(rst), .slot(slot));

  biq_pipe_add #(.W(W)) u_add (
    .clk(clk), .rst(rst), .a(add_a), .b(add_b), .q(add_q));

  biq_pipe_mul #(.W(W), .F(F)) u_mul (
    .clk(clk), .rst(rst), .a(mul_a), .b(mul_k), .q(mul_q));

  biq_tapline #(.W(W), .DEPTH(ADD_DEPTH)) u_add_line (
    .clk(clk), .rst(rst), .d(add_q), .taps(add_taps));

  biq_tapline #(.W(W), .DEPTH(MUL_DEPTH)) u_mul_line (
    .clk(clk), .rst(rst), .d(mul_q), .taps(mul_taps));

  // operand routing: each slot selects the taps its scheduled operations need
  always_comb begin
    unique case (slot)
      slot_t'(ORD_ADD4): begin
        add_a = mul_taps[H_6_4]; add_b = mul_taps[H_8_4];
        mul_a = add_taps[H_1_5]; mul_k = K_A;
      end
      slot_t'(ORD_ADD2): begin
        add_a = add_taps[H_1_2]; add_b = add_taps[H_4_2];
        mul_a = add_taps[H_1_8]; mul_k = K_D;
      end
      slot_t'(ORD_ADD3): begin
        add_a = mul_taps[H_5_3]; add_b = mul_taps[H_7_3];
        mul_a = add_taps[H_1_6]; mul_k = K_B;
      end
      default: begin
        add_a = x_hold;          add_b = add_taps[H_3_1];
        mul_a = add_taps[H_1_7]; mul_k = K_C;
      end
    endcase
  end

  assign in_ready = (slot == LOAD_SLOT);

  always_ff @(posedge clk) begin
    if (rst)           x_hold <= '0;
    else if (in_ready) x_hold <= in_valid ? in_data : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= (slot == CAP_SLOT);
      if (slot == CAP_SLOT) y_q <= add_taps[0];
    end
  end

  assign y_out = y_q;

  AST_READY_THEN_STROBE: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> out_valid); // R2
  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2
  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(x_hold)); // R3
  AST_Y_HELD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(y_out)); // R7
  AST_OLDEST_STATE: assert property (@(posedge clk) disable iff (rst)
    add_taps[ADD_DEPTH] == $past(add_taps[ADD_DEPTH-1]) || $past(rst)); // R4
endmodule

// File: tb/biq_folded_test.sv
`timescale 1ns/1ps
module biq_folded_test;
  localparam int W  = 16;
  localparam int F  = 14;
  localparam int CA = 8192;
  localparam int CB = 12288;
  localparam int CC = -4096;
  localparam int CD = -6144;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         in_ready, out_valid;
  logic [W-1:0] y_out;

  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  bit     done   = 0;
  string  tag    = "R4";
  longint wv [0:1023];
  longint last_y = 0;

  always #2 clk = ~clk;

  biq_folded #(.W(W), .F(F), .COEF_A(CA), .COEF_B(CB), .COEF_C(CC), .COEF_D(CD)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .y_out(y_out));

  // R6: floor(c*v / 2^F), then modulo 2^W into signed range
  function automatic longint mq(longint c, longint v);
    longint p, q;
    p = c * v;
    q = p / (longint'(1) << F);
    if (p < 0 && (p % (longint'(1) << F)) != 0) q = q - 1;
    return q;
  endfunction

  function automatic longint wr(longint v);
    longint m;
    m = v % 65536;
    if (m < 0) m = m + 65536;
    if (m >= 32768) m = m - 65536;
    return m;
  endfunction

  function automatic longint yref(int l);
    return wr(wv[l+2] + mq(CB, wv[l+1]) + mq(CD, wv[l]));
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) wv[i] = 0;
    last_y = 0;
    cyc = 0;
  endtask

  task automatic check_cycle();
    int     s;
    longint got;
    s = cyc % 4;
    checks++;
    if (in_ready !== (s == 2) || out_valid !== (s == 3)) begin
      fails++;
      $display("FAIL R2 cycle %0d: ready/valid = %b%b expected %b%b",
               cyc, in_ready, out_valid, (s == 2), (s == 3));
    end
    got = longint'($signed(y_out));
    checks++;
    if (s == 3) begin
      last_y = yref(cyc / 4);
      if (got !== last_y) begin
        fails++;
        $display("FAIL %s iteration %0d: y_out = %0d expected %0d", tag, cyc / 4, got, last_y);
      end
    end else if (got !== last_y) begin
      fails++;
      $display("FAIL R7 cycle %0d: y_out = %0d expected held %0d", cyc, got, last_y);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] d);
    longint x;
    int     l;
    check_cycle();
    in_valid = v;
    in_data  = d;
    if (cyc % 4 == 2) begin
      x = v ? longint'($signed(d)) : 0;
      l = cyc / 4;
      wv[l+3] = wr(x + mq(CA, wv[l+2]) + mq(CC, wv[l+1]));
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  // one iteration: window sample plus optional stray strobe/data elsewhere
  task automatic iter(input logic v, input logic [W-1:0] d, input logic stray);
    for (int s = 0; s < 4; s++)
      step((s == 2) ? v : stray, (s == 2) ? d : (stray ? 16'h7fff : 16'h0));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 16'h1234;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || y_out !== '0 || in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: valid=%b y=%0d ready=%b expected 0 0 0",
               out_valid, y_out, in_ready);
    end
    rst = 1'b0;
    in_valid = 1'b0;
    model_clear();
  endtask

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    do_reset();

    // R5: isolated impulse, then explicit latency checks at the strobes
    tag = "R5";
    iter(1'b1, 16'd4096, 1'b0);
    checks++;
    if (y_out !== 16'd0) begin
      fails++; $display("FAIL R5 same-iteration strobe: y_out = %0d expected 0", y_out);
    end
    iter(1'b1, 16'd0, 1'b0);
    checks++;
    if (y_out !== 16'd4096) begin
      fails++; $display("FAIL R5 next-iteration strobe: y_out = %0d expected 4096", y_out);
    end
    for (int i = 0; i < 10; i++) iter(1'b1, 16'd0, 1'b0);

    // R4: step and a varying pattern
    tag = "R4";
    for (int i = 0; i < 20; i++) iter(1'b1, 16'd3000, 1'b0);
    for (int i = 0; i < 20; i++) iter(1'b1, W'((i * 1733) % 9000 - 4500), 1'b0);

    // R3: empty windows and stray strobes outside the window
    tag = "R3";
    for (int i = 0; i < 16; i++) iter(i[0], 16'd2500, i[1]);

    // R6: full-range samples forcing wrap-around
    tag = "R6";
    for (int i = 0; i < 60; i++) iter(1'b1, W'($urandom), 1'b0);
    for (int i = 0; i < 8; i++) iter(1'b1, 16'h7fff, 1'b0);
    for (int i = 0; i < 8; i++) iter(1'b1, 16'h8000, 1'b0);

    // R8: reset mid-run, then the filter starts from zero state again
    iter(1'b1, 16'd5000, 1'b0);
    step(1'b1, 16'd700);
    do_reset();
    tag = "R8";
    iter(1'b1, 16'd4096, 1'b0);
    for (int i = 0; i < 20; i++) iter(1'b1, W'((i * 911) % 6000 - 3000), 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule